// File: doc/BRIEF.md
# Electrochromic Drive Mode Controller

This block is the digital control layer of an electrochromic mirror driver. It holds a small configuration word and turns it into gate-enable commands. The word covers supply routing, driver enable, target code, full-scale range, discharge enable, PWM-discharge select and dead time. The commands go to a high-side charge path and a low-side discharge switch. A further pair of outputs settles how a shared high-side output is used. Either the output is taken over as the charge-path supply, or it runs as an independent load driver under its own configuration. The analog loop, the comparators and the shape of the PWM discharge waveform live elsewhere. A PWM discharge waveform comes in on a pin and is only gated through to the discharge switch.

Internally a sequencer picks one of four states: idle, regulate, discharge and dead. Every switch turn-on goes through the dead state, so the charge and discharge paths can never overlap. Clearing the enable or changing the target drops the active switch in the same cycle that the new configuration takes effect.

Top module: `ecd_mode_ctrl`

## Requirements
- R1: After reset, the shared-output override is 1, the full-scale output reads 1200, and both switch enables are 0. The state output reads 0 (idle) and the stored dead time is 2.
- R2: While the stored supply-mode bit is 1, `shr_out_en` equals `hs_chg_en`. The inputs `ld_on`, `ld_pwm_sel` and `ld_pwm_in` have no effect in this mode.
- R3: `itrip_en` is 0 while the supply-mode bit is 1, and equals `ld_itrip_req` while it is 0.
- R4: While the supply-mode bit is 0, `shr_out_en` is `ld_pwm_in` when `ld_pwm_sel` is 1 and `ld_on` otherwise. The charge path is still driven by the sequencer.
- R5: With enable 1 and a non-zero target, the sequencer settles in regulate (state 1) with `hs_chg_en` = 1.
- R6: `ls_dis_en` is held at 1 (state 2) only when all four hold: PWM select is 0, target is 0, discharge enable is 1 and enable is 1. With target 0 and discharge enable 0, the block idles with both switches off.
- R7: With PWM select 1, target 0, discharge enable 1 and enable 1, `ls_dis_en` follows `dis_pwm_in`.
- R8: With discharge enable left at 1, writing a non-zero target leaves discharge and returns to regulate.
- R9: `hs_chg_en` and `ls_dis_en` are never 1 in the same cycle.
- R10: Before any switch turns on, the sequencer spends max(dead, 1) cycles in the dead state (state 3) with both switches off. Entry into the dead state happens on the clock edge after the configuration update.
- R11: Writing enable 0 drops both switches in the cycle right after the write edge, and the state reads idle one edge later.
- R12: `full_scale_mv` reads 1200 when the full-scale bit is 0 and 1500 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_supply_mode | input | 1 | 1: shared output supplies the charge path |
| cfg_en | input | 1 | Driver enable |
| cfg_target | input | TGT_W | Target voltage code |
| cfg_fs_high | input | 1 | Full-scale select |
| cfg_dis_en | input | 1 | Discharge enable |
| cfg_pwm_dis | input | 1 | Select PWM discharge instead of fast discharge |
| cfg_dead | input | DEAD_W | Dead time in cycles (0 acts as 1) |
| ld_on | input | 1 | Shared output own on/off setting |
| ld_pwm_sel | input | 1 | Shared output own PWM select |
| ld_pwm_in | input | 1 | Shared output own PWM waveform |
| ld_itrip_req | input | 1 | Current-trip regulation requested for the shared output |
| dis_pwm_in | input | 1 | PWM discharge waveform |
| hs_chg_en | output | 1 | Charge path gate enable |
| ls_dis_en | output | 1 | Discharge switch gate enable |
| shr_out_en | output | 1 | Shared high-side output enable |
| shr_ec_override | output | 1 | Shared output taken over as charge supply |
| itrip_en | output | 1 | Current-trip regulation enable for shared output |
| target_code | output | TGT_W | Stored target code for the analog loop |
| full_scale_mv | output | FS_W | Full-scale range in millivolts |
| state_out | output | 2 | Sequencer state: 0 idle, 1 regulate, 2 discharge, 3 dead |

## Verification
A vector table walks the configurations that separate the states. Regulate is exercised in both supply modes. Fast discharge is set against PWM discharge with the waveform both high and low. Target zero without discharge enable and a cleared enable are also covered. Each vector sets the shared output's own inputs against the expected value, which shows whether they are ignored or followed. Directed runs count the dead-state cycles for a dead time of 3 and of 0. They also check that a target change or a cleared enable drops the active switch in the cycle after the write.

// File: rtl/ecd_pkg.sv
package ecd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REG  = 2'd1,
        ST_DIS  = 2'd2,
        ST_DEAD = 2'd3
    } ecd_state_e;
endpackage

// File: rtl/ecd_cfg_regs.sv
module ecd_cfg_regs #(
    parameter int TGT_W    = 4,
    parameter int DEAD_W   = 4,
    parameter int DEAD_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              supply_mode_in,
    input  logic              en_in,
    input  logic [TGT_W-1:0]  target_in,
    input  logic              fs_high_in,
    input  logic              dis_en_in,
    input  logic              pwm_dis_in,
    input  logic [DEAD_W-1:0] dead_in,
    output logic              supply_mode,
    output logic              en,
    output logic [TGT_W-1:0]  target,
    output logic              fs_high,
    output logic              dis_en,
    output logic              pwm_dis,
    output logic [DEAD_W-1:0] dead
);
    typedef struct packed {
        logic              supply_mode;
        logic              en;
        logic [TGT_W-1:0]  target;
        logic              fs_high;
        logic              dis_en;
        logic              pwm_dis;
        logic [DEAD_W-1:0] dead;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        supply_mode: 1'b1,
        en:          1'b0,
        target:      '0,
        fs_high:     1'b0,
        dis_en:      1'b0,
        pwm_dis:     1'b0,
        dead:        DEAD_W'(DEAD_RST)
    };

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.supply_mode = supply_mode_in;
            cfg_d.en          = en_in;
            cfg_d.target      = target_in;
            cfg_d.fs_high     = fs_high_in;
            cfg_d.dis_en      = dis_en_in;
            cfg_d.pwm_dis     = pwm_dis_in;
            cfg_d.dead        = dead_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign supply_mode = cfg_q.supply_mode;
    assign en          = cfg_q.en;
    assign target      = cfg_q.target;
    assign fs_high     = cfg_q.fs_high;
    assign dis_en      = cfg_q.dis_en;
    assign pwm_dis     = cfg_q.pwm_dis;
    assign dead        = cfg_q.dead;
endmodule

// File: rtl/ecd_seq.sv
module ecd_seq
    import ecd_pkg::*;
#(
    parameter int TGT_W  = 4,
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TGT_W-1:0]  target,
    input  logic              dis_en,
    input  logic              pwm_dis,
    input  logic [DEAD_W-1:0] dead,
    input  logic              pwm_wave,
    output logic              hs_on,
    output logic              ls_on,
    output ecd_state_e        state
);
    typedef struct packed {
        ecd_state_e        st;
        logic [DEAD_W-1:0] cnt;
    } seq_t;

    seq_t       seq_d, seq_q;
    ecd_state_e want;
    logic [DEAD_W-1:0] dead_load;

    always_comb begin
        if (!en)                   want = ST_IDLE;
        else if (target != '0)     want = ST_REG;
        else if (dis_en)           want = ST_DIS;
        else                       want = ST_IDLE;
    end

    assign dead_load = (dead == '0) ? '0 : dead - DEAD_W'(1);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (want != ST_IDLE) begin
                    seq_d.st  = ST_DEAD;
                    seq_d.cnt = dead_load;
                end
            end
            ST_REG, ST_DIS: begin
                if (want == ST_IDLE) begin
                    seq_d.st = ST_IDLE;
                end else if (want != seq_q.st) begin
                    seq_d.st  = ST_DEAD;
                    seq_d.cnt = dead_load;
                end
            end
            ST_DEAD: begin
                if (want == ST_IDLE)        seq_d.st = ST_IDLE;
                else if (seq_q.cnt == '0)   seq_d.st = want;
                else                        seq_d.cnt = seq_q.cnt - DEAD_W'(1);
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign hs_on = (seq_q.st == ST_REG) && (want == ST_REG);
    assign ls_on = (seq_q.st == ST_DIS) && (want == ST_DIS) && (!pwm_dis || pwm_wave);
    assign state = seq_q.st;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on)); // R9
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (seq_q.st == ST_IDLE)); // R11
    AST_DEAD_BEFORE_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> ($past(seq_q.st) == ST_DEAD)); // R10
    AST_DEAD_BEFORE_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_DIS) && ($past(seq_q.st) != ST_DIS)) |-> ($past(seq_q.st) == ST_DEAD)); // R10
endmodule

// File: rtl/ecd_out_mux.sv
module ecd_out_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_mode,
    input  logic hs_on,
    input  logic ld_on,
    input  logic ld_pwm_sel,
    input  logic ld_pwm_in,
    input  logic ld_itrip_req,
    output logic shr_out_en,
    output logic shr_override,
    output logic itrip_en
);
    logic own_en;

    always_comb begin
        own_en       = ld_pwm_sel ? ld_pwm_in : ld_on;
        shr_out_en   = supply_mode ? hs_on : own_en;
        shr_override = supply_mode;
        itrip_en     = ld_itrip_req && !supply_mode;
    end

    AST_ITRIP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        shr_override |-> !itrip_en); // R3
    AST_SUPPLY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        shr_override |-> (shr_out_en == hs_on)); // R2
endmodule

// File: rtl/ecd_mode_ctrl.sv
module ecd_mode_ctrl
    import ecd_pkg::*;
#(
    parameter int TGT_W     = 4,
    parameter int DEAD_W    = 4,
    parameter int DEAD_RST  = 2,
    parameter int FS_W      = 11,
    parameter int FS_LO_MV  = 1200,
    parameter int FS_HI_MV  = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_supply_mode,
    input  logic              cfg_en,
    input  logic [TGT_W-1:0]  cfg_target,
    input  logic              cfg_fs_high,
    input  logic              cfg_dis_en,
    input  logic              cfg_pwm_dis,
    input  logic [DEAD_W-1:0] cfg_dead,
    input  logic              ld_on,
    input  logic              ld_pwm_sel,
    input  logic              ld_pwm_in,
    input  logic              ld_itrip_req,
    input  logic              dis_pwm_in,
    output logic              hs_chg_en,
    output logic              ls_dis_en,
    output logic              shr_out_en,
    output logic              shr_ec_override,
    output logic              itrip_en,
    output logic [TGT_W-1:0]  target_code,
    output logic [FS_W-1:0]   full_scale_mv,
    output logic [1:0]        state_out
);
    localparam logic [FS_W-1:0] FS_LO = FS_W'(FS_LO_MV);
    localparam logic [FS_W-1:0] FS_HI = FS_W'(FS_HI_MV);

    logic              r_mode, r_en, r_fs, r_dis, r_pwm;
    logic [TGT_W-1:0]  r_tgt;
    logic [DEAD_W-1:0] r_dead;
    logic              hs_on, ls_on;
    ecd_state_e        st;

    ecd_cfg_regs #(.TGT_W(TGT_W), .DEAD_W(DEAD_W), .DEAD_RST(DEAD_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .supply_mode_in(cfg_supply_mode), .en_in(cfg_en), .target_in(cfg_target),
        .fs_high_in(cfg_fs_high), .dis_en_in(cfg_dis_en), .pwm_dis_in(cfg_pwm_dis),
        .dead_in(cfg_dead),
        .supply_mode(r_mode), .en(r_en), .target(r_tgt), .fs_high(r_fs),
        .dis_en(r_dis), .pwm_dis(r_pwm), .dead(r_dead)
    );

    ecd_seq #(.TGT_W(TGT_W), .DEAD_W(DEAD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(r_en), .target(r_tgt), .dis_en(r_dis),
        .pwm_dis(r_pwm), .dead(r_dead), .pwm_wave(dis_pwm_in),
        .hs_on(hs_on), .ls_on(ls_on), .state(st)
    );

    ecd_out_mux u_mux (
        .clk(clk), .rst_n(rst_n), .supply_mode(r_mode), .hs_on(hs_on),
        .ld_on(ld_on), .ld_pwm_sel(ld_pwm_sel), .ld_pwm_in(ld_pwm_in),
        .ld_itrip_req(ld_itrip_req), .shr_out_en(shr_out_en),
        .shr_override(shr_ec_override), .itrip_en(itrip_en)
    );

    assign hs_chg_en     = hs_on;
    assign ls_dis_en     = ls_on;
    assign target_code   = r_tgt;
    assign full_scale_mv = r_fs ? FS_HI : FS_LO;
    assign state_out     = st;

    AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !r_en |-> (!hs_chg_en && !ls_dis_en)); // R11
endmodule

// File: tb/ecd_mode_ctrl_test.sv
`timescale 1ns/1ps
module ecd_mode_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_supply_mode = 1'b1, cfg_en = 1'b0;
    logic [3:0] cfg_target = '0;
    logic cfg_fs_high = 1'b0, cfg_dis_en = 1'b0, cfg_pwm_dis = 1'b0;
    logic [3:0] cfg_dead = 4'd2;
    logic ld_on = 1'b0, ld_pwm_sel = 1'b0, ld_pwm_in = 1'b0, ld_itrip_req = 1'b0;
    logic dis_pwm_in = 1'b0;
    logic hs_chg_en, ls_dis_en, shr_out_en, shr_ec_override, itrip_en;
    logic [3:0] target_code;
    logic [10:0] full_scale_mv;
    logic [1:0] state_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ecd_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_supply_mode(cfg_supply_mode),
        .cfg_en(cfg_en), .cfg_target(cfg_target), .cfg_fs_high(cfg_fs_high),
        .cfg_dis_en(cfg_dis_en), .cfg_pwm_dis(cfg_pwm_dis), .cfg_dead(cfg_dead),
        .ld_on(ld_on), .ld_pwm_sel(ld_pwm_sel), .ld_pwm_in(ld_pwm_in),
        .ld_itrip_req(ld_itrip_req), .dis_pwm_in(dis_pwm_in),
        .hs_chg_en(hs_chg_en), .ls_dis_en(ls_dis_en), .shr_out_en(shr_out_en),
        .shr_ec_override(shr_ec_override), .itrip_en(itrip_en),
        .target_code(target_code), .full_scale_mv(full_scale_mv), .state_out(state_out)
    );

    typedef struct packed {
        bit mode; bit en; bit [3:0] tgt; bit dis; bit pwm; bit pin;
        bit lon; bit lsel; bit lpin; bit itr;
        bit e_hs; bit e_ls; bit e_shr; bit e_itr; bit [1:0] e_st;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // mode en tgt  dis pwm pin lon lsel lpin itr | hs ls shr itr st
        '{1'b1,1'b1,4'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b0,2'd1}, // R5 R2 R3
        '{1'b1,1'b1,4'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b0,2'd2}, // R6 R2
        '{1'b1,1'b1,4'd0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0,2'd2}, // R7 R2
        '{1'b1,1'b1,4'd0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd2}, // R7
        '{1'b1,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0}, // R6
        '{1'b0,1'b1,4'd9,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b1,2'd1}, // R4 R3
        '{1'b0,1'b1,4'd9,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b1,1'b0,2'd1}, // R4
        '{1'b0,1'b0,4'd9,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,2'd0}, // R11 R4
        '{1'b0,1'b1,4'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0,2'd2}  // R6 R4
    };

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(bit mode, bit en, bit [3:0] tgt, bit fs, bit dis, bit pwm, bit [3:0] dead);
        cfg_supply_mode = mode; cfg_en = en; cfg_target = tgt; cfg_fs_high = fs;
        cfg_dis_en = dis; cfg_pwm_dis = pwm; cfg_dead = dead; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    always @(negedge clk) if (rst_n && hs_chg_en && ls_dis_en) check("R9 overlap", 16'd1, 16'd0);

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 override", 16'(shr_ec_override), 16'd1);
        check("R1 full scale", 16'(full_scale_mv), 16'd1200);
        check("R1 hs", 16'(hs_chg_en), 16'd0);
        check("R1 ls", 16'(ls_dis_en), 16'd0);
        check("R1 state", 16'(state_out), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: stored dead time 2 -> two dead cycles before regulate
        wr(1'b1, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0, 4'd2);
        check("R1 dead default (write cycle)", 16'(state_out), 16'd0);
        @(negedge clk); check("R1 dead default c1", 16'(state_out), 16'd3);
        @(negedge clk); check("R1 dead default c2", 16'(state_out), 16'd3);
        @(negedge clk); check("R1 dead default on", 16'(hs_chg_en), 16'd1);
        wr(1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd2);
        repeat (2) @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            ld_on = VECS[i].lon; ld_pwm_sel = VECS[i].lsel; ld_pwm_in = VECS[i].lpin;
            ld_itrip_req = VECS[i].itr; dis_pwm_in = VECS[i].pin;
            wr(VECS[i].mode, VECS[i].en, VECS[i].tgt, 1'b0, VECS[i].dis, VECS[i].pwm, 4'd2);
            repeat (6) @(negedge clk);
            check($sformatf("R5/R6/R7 vec%0d hs", i), 16'(hs_chg_en), 16'(VECS[i].e_hs));
            check($sformatf("R6/R7 vec%0d ls", i), 16'(ls_dis_en), 16'(VECS[i].e_ls));
            check($sformatf("R2/R4 vec%0d shr", i), 16'(shr_out_en), 16'(VECS[i].e_shr));
            check($sformatf("R3 vec%0d itrip", i), 16'(itrip_en), 16'(VECS[i].e_itr));
            check($sformatf("R5 vec%0d state", i), 16'(state_out), 16'(VECS[i].e_st));
            check($sformatf("R2 vec%0d override", i), 16'(shr_ec_override), 16'(VECS[i].mode));
        end
        ld_on = 0; ld_pwm_sel = 0; ld_pwm_in = 0; ld_itrip_req = 0; dis_pwm_in = 0;
        wr(1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd2);
        repeat (3) @(negedge clk);

        // R10: dead time 3 from idle
        wr(1'b1, 1'b1, 4'd3, 1'b0, 1'b1, 1'b0, 4'd3);
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            check($sformatf("R10 dead3 state c%0d", c), 16'(state_out), 16'd3);
            check($sformatf("R10 dead3 hs c%0d", c), 16'(hs_chg_en), 16'd0);
        end
        @(negedge clk);
        check("R10 dead3 hs on", 16'(hs_chg_en), 16'd1);
        // R10 switch to discharge, hs drops at once
        wr(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0, 4'd3);
        check("R10 hs drops on write", 16'(hs_chg_en), 16'd0);
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            check($sformatf("R10 dis dead ls c%0d", c), 16'(ls_dis_en), 16'd0);
        end
        @(negedge clk);
        check("R10 ls on after dead", 16'(ls_dis_en), 16'd1);

        // R8: non-zero target with discharge enable still 1; dead 0 acts as 1
        wr(1'b1, 1'b1, 4'd7, 1'b0, 1'b1, 1'b0, 4'd0);
        check("R8 ls drops on write", 16'(ls_dis_en), 16'd0);
        @(negedge clk);
        check("R10 dead0 one cycle", 16'(state_out), 16'd3);
        @(negedge clk);
        check("R8 back to regulate", 16'(state_out), 16'd1);
        check("R8 hs on", 16'(hs_chg_en), 16'd1);

        // R11: enable cleared
        wr(1'b1, 1'b0, 4'd7, 1'b0, 1'b1, 1'b0, 4'd0);
        check("R11 hs off after write", 16'(hs_chg_en), 16'd0);
        check("R2 shared off with charge", 16'(shr_out_en), 16'd0);
        @(negedge clk);
        check("R11 idle", 16'(state_out), 16'd0);

        // R12 full-scale select
        wr(1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 4'd2);
        check("R12 high scale", 16'(full_scale_mv), 16'd1500);
        wr(1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd2);
        check("R12 low scale", 16'(full_scale_mv), 16'd1200);
        check("R5 target code out", 16'(target_code), 16'd0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule